// File: doc/BRIEF.md
# Interrupt Priority Stack with Acknowledge

This block keeps track of the running priority while interrupts nest. It holds a current-priority register and a last-in-first-out stack of the priorities that were interrupted. The block takes a winning request from an external arbiter as a vector number and a priority. It raises the processor interrupt line only when that priority is strictly above the current one. While the line is being raised, the block captures the request's vector and priority.

Software reads the acknowledge register and gets a vector word. That word is built from a programmable table base address and the captured vector number. The same read pushes the old current priority onto the stack and makes the captured priority current. When the service routine finishes, software writes the end-of-interrupt register, and the most recent stacked priority returns to the current-priority register. Sticky flags report a push into a full stack and a pop from an empty one. An entry-size mode input moves the vector field up by one bit, for tables whose entries are twice as wide.

The register map is at fixed byte offsets:

- `0x00` is the table base. It can be read and written, with byte-lane enables.
- `0x08` is the current priority. It is read-only and zero-extended.
- `0x10` is the acknowledge register. It is read-only.
- `0x18` is the end-of-interrupt register. It is write-only and reads as zero.

Read data is combinational during the access cycle. Every side effect takes place at the clock edge that ends the access.

Top module: `prio_ack_ctrl`

## Requirements
- R1: After reset the current priority is 0, the interrupt line is low, both flags are low, and reads of offsets 0x00 and 0x08 return 0.
- R2: The interrupt line is high one edge after the inputs are applied, and only when win_valid is 1 and win_pri is strictly greater than the current priority. It is low when win_pri is equal to the current priority or below it, and low when win_valid is 0.
- R3: With entry_mode = 0, an acknowledge read (offset 0x10) returns a word made of three fields. Bits [31:11] hold the stored base, which is base register bits [31:11]. Bits [10:2] hold the captured 9-bit vector. Bits [1:0] are 0.
- R4: With entry_mode = 1, an acknowledge read returns a different layout. Bits [31:12] hold base register bits [31:12]. Bits [11:3] hold the captured vector. Bits [2:0] are 0.
- R5: An acknowledge read pushes the current priority and, at the end of the access, loads the captured priority into the current priority. The new value is readable at offset 0x08.
- R6: Any write to offset 0x18 pops the most recently pushed priority into the current priority, whatever the data or byte enables.
- R7: A write to offset 0x18 changes no register contents other than the pop. In particular, the base register read at 0x00 is unchanged.
- R8: A read of offset 0x18 returns 0 and leaves the current priority and the stack unchanged.
- R9: The stack holds 14 entries. A push while it is full discards the pushed value and sets the sticky overflow flag. The current priority is still loaded, and later pops return the 14 stored entries newest first.
- R10: A pop from an empty stack sets the sticky underflow flag and leaves the current priority at 0. The flag stays set until reset.
- R11: While the interrupt line is raised, the captured vector and priority follow the winning request. A new, higher winner is therefore reported by the next acknowledge read.
- R12: A write to offset 0x00 updates only the byte lanes whose bus_be bit is set. Bits [10:0] of the base register always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| win_valid | input | 1 | Winning request present |
| win_vec | input | 9 | Vector number of the winning request |
| win_pri | input | 4 | Priority of the winning request |
| entry_mode | input | 1 | Vector-table entry size: 0 = narrow, 1 = wide |
| irq_out | output | 1 | Interrupt request to the processor |
| cur_pri | output | 4 | Current priority |
| ovf_flag | output | 1 | Sticky stack-overflow flag |
| unf_flag | output | 1 | Sticky stack-underflow flag |

## Verification
Read data is combinational, so the monitor compares each read during the access cycle itself. It samples one nanosecond after the falling edge at which the driver placed the access.

Stack, priority and flag effects are registered at the rising edge that ends the access. The bench checks them at the following falling edge, when the driver task returns. The interrupt line and the vector capture have one register stage, so a change of win_valid or win_pri is checked one falling edge after it is applied.

// File: rtl/prio_ack_pkg.sv
package prio_ack_pkg;
    localparam int BUS_W = 32;
    localparam int ADR_W = 8;
    localparam logic [ADR_W-1:0] OFF_BASE = 8'h00;
    localparam logic [ADR_W-1:0] OFF_CUR  = 8'h08;
    localparam logic [ADR_W-1:0] OFF_ACK  = 8'h10;
    localparam logic [ADR_W-1:0] OFF_EOI  = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_CUR,
        SEL_ACK,
        SEL_EOI
    } reg_sel_e;
endpackage

// File: rtl/prio_lifo.sv
module prio_lifo #(
    parameter int DEPTH = 14,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val,
    output logic         ovf,
    output logic         unf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
        logic                    unf;
    } lifo_t;

    lifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            if (st_q.cnt == FULL) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.mem[st_q.cnt] = push_val;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (pop) begin
            if (st_q.cnt == '0) begin
                st_d.unf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_val = (st_q.cnt == '0) ? '0 : st_q.mem[CNT_W'(st_q.cnt - 1'b1)];
    assign ovf     = st_q.ovf;
    assign unf     = st_q.unf;

    // R9: occupancy never exceeds the depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R9: push into a full stack keeps it full and raises the flag
    a_r9_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == FULL) |=> (st_q.cnt == FULL && ovf));

    // R10: pop from empty raises underflow and stays empty
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (unf && st_q.cnt == '0));

    // R10: underflow flag is sticky
    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);
endmodule

// File: rtl/ack_word_fmt.sv
module ack_word_fmt #(
    parameter int VEC_W = 9,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-VEC_W-3:0] base,
    input  logic [VEC_W-1:0]        vec,
    input  logic                    wide,
    output logic [WORD_W-1:0]       word
);
    localparam int BASE_W = WORD_W - VEC_W - 2;

    logic [WORD_W-1:0] narrow_word;
    logic [WORD_W-1:0] wide_word;

    assign narrow_word = {base, vec, 2'b00};
    assign wide_word   = {base[BASE_W-1:1], vec, 3'b000};
    assign word        = wide ? wide_word : narrow_word;
endmodule

// File: rtl/prio_ack_ctrl.sv
module prio_ack_ctrl
    import prio_ack_pkg::*;
#(
    parameter int VEC_W = 9,
    parameter int PRI_W = 4,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [3:0]       bus_be,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             win_valid,
    input  logic [VEC_W-1:0] win_vec,
    input  logic [PRI_W-1:0] win_pri,
    input  logic             entry_mode,
    output logic             irq_out,
    output logic [PRI_W-1:0] cur_pri,
    output logic             ovf_flag,
    output logic             unf_flag
);
    localparam int BASE_W = BUS_W - VEC_W - 2;
    localparam int LOW_W  = BUS_W - BASE_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [VEC_W-1:0]  vec;
        logic [PRI_W-1:0]  pri;
        logic [PRI_W-1:0]  cur;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    reg_sel_e         sel;
    logic             rd_acc, wr_acc;
    logic             ack_rd, eoi_wr, eoi_rd, base_wr;
    logic [PRI_W-1:0] stk_top;
    logic [BUS_W-1:0] base_merge;
    logic [BUS_W-1:0] ack_word;

    always_comb begin
        case (bus_addr)
            OFF_BASE: sel = SEL_BASE;
            OFF_CUR:  sel = SEL_CUR;
            OFF_ACK:  sel = SEL_ACK;
            OFF_EOI:  sel = SEL_EOI;
            default:  sel = SEL_NONE;
        endcase
    end

    assign rd_acc  = bus_sel && !bus_wr;
    assign wr_acc  = bus_sel && bus_wr;
    assign ack_rd  = rd_acc && (sel == SEL_ACK);
    assign eoi_rd  = rd_acc && (sel == SEL_EOI);
    assign eoi_wr  = wr_acc && (sel == SEL_EOI);
    assign base_wr = wr_acc && (sel == SEL_BASE);

    always_comb begin
        base_merge = {r_q.base, {LOW_W{1'b0}}};
        for (int b = 0; b < 4; b++) begin
            if (bus_be[b]) base_merge[8*b +: 8] = bus_wdata[8*b +: 8];
        end
    end

    always_comb begin
        r_d = r_q;
        if (base_wr) r_d.base = base_merge[BUS_W-1:LOW_W];
        if (ack_rd)      r_d.cur = r_q.pri;
        else if (eoi_wr) r_d.cur = stk_top;
        r_d.irq = win_valid && (win_pri > r_d.cur);
        if (r_d.irq) begin
            r_d.vec = win_vec;
            r_d.pri = win_pri;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    prio_lifo #(.DEPTH(DEPTH), .W(PRI_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_rd),
        .pop      (eoi_wr),
        .push_val (r_q.cur),
        .top_val  (stk_top),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );

    ack_word_fmt #(.VEC_W(VEC_W), .WORD_W(BUS_W)) u_fmt (
        .base (r_q.base),
        .vec  (r_q.vec),
        .wide (entry_mode),
        .word (ack_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (sel)
                SEL_BASE: bus_rdata = {r_q.base, {LOW_W{1'b0}}};
                SEL_CUR:  bus_rdata = BUS_W'(r_q.cur);
                SEL_ACK:  bus_rdata = ack_word;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = r_q.irq;
    assign cur_pri = r_q.cur;

    // R2: a raised line always carries a priority above the current one
    a_r2_irq_above_cur: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (r_q.pri > r_q.cur));

    // R5: acknowledge makes the captured priority current
    a_r5_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (cur_pri == $past(r_q.pri)));

    // R6: end-of-interrupt write restores the stacked priority
    a_r6_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> (cur_pri == $past(stk_top)));

    // R7: end-of-interrupt write leaves the base register alone
    a_r7_eoi_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> $stable(r_q.base));

    // R8: end-of-interrupt read has no side effect and reads zero
    a_r8_eoi_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_rd |-> (bus_rdata == '0) ##1 $stable(cur_pri));
endmodule

// File: tb/tb_prio_ack_ctrl.sv
`timescale 1ns/1ps
module tb_prio_ack_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        win_valid = 1'b0;
    logic [8:0]  win_vec = '0;
    logic [3:0]  win_pri = '0;
    logic        entry_mode = 1'b0;
    logic        irq_out;
    logic [3:0]  cur_pri;
    logic        ovf_flag, unf_flag;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] base_word;

    always #2 clk = ~clk;

    prio_ack_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .win_valid(win_valid), .win_vec(win_vec),
        .win_pri(win_pri), .entry_mode(entry_mode), .irq_out(irq_out),
        .cur_pri(cur_pri), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic logic [31:0] ack_exp(input logic wide, input logic [8:0] v);
        if (wide) return (base_word & 32'hFFFF_F000) | (32'(v) << 3);
        return (base_word & 32'hFFFF_F800) | (32'(v) << 2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // monitor: compares read data inside the access cycle
    always begin
        @(negedge clk);
        #1;
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL unexpected read: actual %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cur", 32'(cur_pri), 0);
        chk("R1 irq", 32'(irq_out), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 unf", 32'(unf_flag), 0);
        bus_read(8'h08, 32'h0, "R1 read cur");
        bus_read(8'h00, 32'h0, "R1 read base");

        bus_write(8'h00, 32'hABCD_E8FF, 4'hF);
        base_word = 32'hABCD_E800;
        bus_read(8'h00, base_word, "R12 full base write");
        bus_write(8'h00, 32'h1234_5678, 4'b1000);
        base_word = 32'h12CD_E800;
        bus_read(8'h00, base_word, "R12 byte-lane base write");

        win_valid = 1'b0; win_pri = 4'd5; win_vec = 9'h1A5;
        @(negedge clk);
        chk("R2 irq low without valid", 32'(irq_out), 0);
        win_valid = 1'b1;
        @(negedge clk);
        chk("R2 irq high above cur", 32'(irq_out), 1);
        entry_mode = 1'b0;
        bus_read(8'h10, ack_exp(1'b0, 9'h1A5), "R3 narrow ack word");
        chk("R5 cur after ack", 32'(cur_pri), 5);
        chk("R2 irq low at equal pri", 32'(irq_out), 0);
        bus_read(8'h08, 32'd5, "R5 read cur");

        win_pri = 4'd9; win_vec = 9'h033;
        @(negedge clk);
        chk("R11 irq for new winner", 32'(irq_out), 1);
        entry_mode = 1'b1;
        bus_read(8'h10, ack_exp(1'b1, 9'h033), "R4 R11 wide ack word");
        chk("R5 cur nested", 32'(cur_pri), 9);
        win_valid = 1'b0;

        bus_write(8'h18, 32'hFFFF_FFFF, 4'b0001);
        chk("R6 pop with odd data", 32'(cur_pri), 5);
        bus_read(8'h00, base_word, "R7 base after eoi");
        bus_read(8'h18, 32'h0, "R8 eoi read zero");
        chk("R8 cur after eoi read", 32'(cur_pri), 5);
        bus_write(8'h18, 32'h0, 4'hF);
        chk("R6 pop to zero", 32'(cur_pri), 0);
        chk("R10 no underflow yet", 32'(unf_flag), 0);
        bus_write(8'h18, 32'h0, 4'hF);
        chk("R10 underflow set", 32'(unf_flag), 1);
        chk("R10 cur stays zero", 32'(cur_pri), 0);
        @(negedge clk);
        chk("R10 underflow sticky", 32'(unf_flag), 1);

        entry_mode = 1'b0;
        win_valid = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            win_pri = 4'(k);
            win_vec = 9'(k + 64);
            bus_read(8'h10, ack_exp(1'b0, 9'(k + 64)), "R9 ack during fill");
            chk("R9 cur during fill", 32'(cur_pri), 32'(k));
            if (k == 14) chk("R9 no overflow at depth", 32'(ovf_flag), 0);
        end
        chk("R9 overflow set", 32'(ovf_flag), 1);
        win_valid = 1'b0;
        for (int j = 13; j >= 0; j--) begin
            bus_write(8'h18, 32'h0, 4'hF);
            chk("R9 pop order", 32'(cur_pri), 32'(j));
        end
        chk("R9 overflow sticky", 32'(ovf_flag), 1);

        repeat (2) @(negedge clk);
        chk("R8 all reads consumed", 32'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule